// File: doc/BRIEF.md
# SD Command Line Serializer with CRC7

This block sends one 32-bit word on the SD command line. Each bit takes one generated SD clock. A 7-bit CRC and a closing high bit follow the word, so every accepted word makes exactly 40 SD clock pulses. While it transmits, the block also samples the incoming command line on the rising SD clock edges. The samples taken during the 32 payload clocks are gathered into a word that software can read back as response bits.

Words enter through a valid/ready port. The port accepts a word on any system clock edge where both `in_valid` and `in_ready` are high. `in_ready` is low for the whole frame, so the source must hold its word and valid until the frame ends. A word presented during a frame is not taken and has no effect. Once accepted, a frame cannot be paused. The SD clock runs at the system clock divided by `2*HALF`.

Top module: `sdcmd_serializer`

## Requirements
- R1: A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `busy` and `cmd_oe` read 1 from the next cycle on, and `in_ready` equals `!busy`.
- R2: Each accepted word produces exactly 40 rising edges of `sd_clk`. Each low phase and each high phase lasts `HALF` system cycles, and the first low phase begins right after acceptance.
- R3: At SD clock rises 1 to 32, `cmd_out` carries the accepted word from bit 31 down to bit 0.
- R4: At rises 33 to 39, `cmd_out` carries a CRC7 MSB first. The CRC uses polynomial x^7+x^3+1, starts from zero and is computed over the 32 payload bits in send order.
- R5: At rise 40, `cmd_out` is 1 (the end bit).
- R6: `cmd_out` changes only while `sd_clk` falls or stays low. It is stable across every rising edge.
- R7: `cmd_in` is sampled at rises 1 to 32. The first sample ends up in `rx_data[31]` and the last in `rx_data[0]`. `rx_data` holds its value after the frame.
- R8: `busy` stays high for exactly `80*HALF` system cycles. It falls on the edge where `sd_clk` falls for the 40th time. `rx_done` is high for exactly that one following cycle.
- R9: `in_valid` during a frame is ignored: the transmitted bits do not change, and no second frame starts after it.
- R10: After reset and between frames, `sd_clk` is 0, `cmd_out` is 1, and `cmd_oe`, `busy` and `rx_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Word offered for transmission |
| in_ready | output | 1 | High when a new word can be taken |
| in_data | input | 32 | Word to send, bit 31 first |
| sd_clk | output | 1 | Generated SD clock |
| cmd_out | output | 1 | Command line drive value |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line sampled value |
| busy | output | 1 | Frame in progress |
| rx_data | output | 32 | Bits sampled during the payload clocks |
| rx_done | output | 1 | One-cycle pulse at frame end |

## Verification
Several properties are checked by assertions on every cycle:
- acceptance raises `busy` on the next cycle;
- the half-period counter stays in range;
- `cmd_out` is steady across every SD clock rise;
- the end bit is high;
- the idle line is high with the clock low;
- `rx_done` is a single-cycle pulse;
- the CRC clears to zero at the start of a frame.

Other behaviour only the bench scenarios can show, across a sweep of walking-one, walking-zero and corner words:
- the exact bit order on the line;
- the CRC value;
- the 40-pulse count;
- the `80*HALF` frame length;
- the assembled response word;
- that words offered mid-frame are ignored.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int unsigned CRC_W   = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic din);
    logic fb;
    fb = din ^ cur[CRC_W-1];
    crc_step = {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/sdcmd_clkgen.sv
module sdcmd_clkgen
  import sdcmd_pkg::*;
#(
  parameter int unsigned HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  output logic active,
  output logic sd_clk,
  output logic rise_now,
  output logic fall_now
);
  localparam int unsigned HC_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [HC_W-1:0] HC_END = HC_W'(HALF - 1);

  phase_t          phase;
  logic [HC_W-1:0] hc;

  assign active   = (phase != PH_IDLE);
  assign rise_now = (phase == PH_LOW)  && (hc == HC_END);
  assign fall_now = (phase == PH_HIGH) && (hc == HC_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      hc     <= '0;
      sd_clk <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          hc <= '0;
          if (start) phase <= PH_LOW;
        end
        PH_LOW: begin
          if (rise_now) begin
            phase  <= PH_HIGH;
            hc     <= '0;
            sd_clk <= 1'b1;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        PH_HIGH: begin
          if (fall_now) begin
            phase  <= last ? PH_IDLE : PH_LOW;
            hc     <= '0;
            sd_clk <= 1'b0;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hc <= HC_END);  // R2
  AST_CLK_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_HIGH) |-> sd_clk);  // R2
endmodule

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc_next
);
  logic [CRC_W-1:0] crc;

  assign crc_next = crc_step(crc, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= crc_next;
  end

  AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));  // R4
endmodule

// File: rtl/sdcmd_rx_capture.sv
module sdcmd_rx_capture #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [WORD_W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data <= '0;
    else if (clr) data <= '0;
    else if (en)  data <= {data[WORD_W-2:0], din};
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(data));  // R7
endmodule

// File: rtl/sdcmd_serializer.sv
module sdcmd_serializer
  import sdcmd_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              sd_clk,
  output logic              cmd_out,
  output logic              cmd_oe,
  input  logic              cmd_in,
  output logic              busy,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_done
);
  localparam int unsigned FRAME = WORD_W + CRC_W + 1;
  localparam int unsigned IDX_W = $clog2(FRAME);
  localparam int unsigned TAIL_W = CRC_W + 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME - 1);
  localparam logic [IDX_W-1:0] IDX_PAY_END = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] IDX_WORD = IDX_W'(WORD_W);

  logic              active, rise_now, fall_now, accept, last, in_payload;
  logic [IDX_W-1:0]  bit_idx;
  logic [WORD_W-1:0] shreg;
  logic [TAIL_W-1:0] tail;
  logic [CRC_W-1:0]  crc_next;

  assign accept     = in_valid && in_ready;
  assign in_ready   = !active;
  assign busy       = active;
  assign cmd_oe     = active;
  assign last       = (bit_idx == IDX_LAST);
  assign in_payload = (bit_idx < IDX_WORD);
  assign cmd_out    = !active ? 1'b1 : (in_payload ? shreg[WORD_W-1] : tail[TAIL_W-1]);

  sdcmd_clkgen #(.HALF(HALF)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .last     (last),
    .active   (active),
    .sd_clk   (sd_clk),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  sdcmd_crc7 u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .en       (fall_now && in_payload),
    .din      (shreg[WORD_W-1]),
    .crc_next (crc_next)
  );

  sdcmd_rx_capture #(.WORD_W(WORD_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .en    (rise_now && in_payload),
    .din   (cmd_in),
    .data  (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      shreg   <= '0;
      tail    <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= fall_now && last;
      if (accept) begin
        bit_idx <= '0;
        shreg   <= in_data;
      end else if (fall_now && !last) begin
        bit_idx <= bit_idx + 1'b1;
        if (in_payload) shreg <= {shreg[WORD_W-2:0], 1'b0};
        else            tail  <= {tail[TAIL_W-2:0], 1'b0};
        if (bit_idx == IDX_PAY_END) tail <= {crc_next, 1'b1};
      end
    end
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);  // R1
  AST_CMD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk) |-> $stable(cmd_out));  // R6
  AST_END_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_clk && last) |-> cmd_out);  // R5
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd_out && !sd_clk && !cmd_oe));  // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);  // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> !busy);  // R8
endmodule

// File: tb/sdcmd_serializer_test.sv
module sdcmd_serializer_test;
  localparam int unsigned HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        sd_clk, cmd_out, cmd_oe, busy, rx_done;
  logic        cmd_in = 1'b1;
  logic [31:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  sdcmd_serializer #(.WORD_W(32), .HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in), .busy(busy), .rx_data(rx_data), .rx_done(rx_done)
  );

  function automatic logic [39:0] frame_of(input logic [31:0] w);
    logic [6:0] c;
    logic fb;
    c = '0;
    for (int i = 31; i >= 0; i--) begin
      fb = w[i] ^ c[6];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'b0001001;
    end
    frame_of = {w, c, 1'b1};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [31:0] w, input logic [31:0] resp, input bit poke);
    logic [39:0] seen, exp;
    int rises, cycles, dones;
    bit prev_clk, ready_leak;
    seen = '0; rises = 0; cycles = 0; dones = 0; prev_clk = 1'b0; ready_leak = 1'b0;
    exp = frame_of(w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    cmd_in = resp[31];
    @(negedge clk);
    in_valid = 1'b0; in_data = ~w;
    check("R1 busy after accept", {busy, cmd_oe, in_ready}, 64'b110);
    while (busy && cycles < 2000) begin
      cycles++;
      if (sd_clk && !prev_clk) begin
        if (rises < 40) seen[39-rises] = cmd_out;
        rises++;
      end
      prev_clk = sd_clk;
      if (!sd_clk && rises < 32) cmd_in = resp[31-rises];
      if (poke) begin
        in_valid = (cycles >= 20 && cycles < 60);
        if (in_valid && in_ready) ready_leak = 1'b1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    if (rx_done) dones++;
    @(negedge clk);
    if (rx_done) dones++;
    check("R2 rise count", rises, 40);
    check("R8 busy length", cycles, 80*HALF);
    check("R8 done pulse", dones, 1);
    check("R3 payload bits", seen[39:8], exp[39:8]);
    check("R4 crc7 bits", seen[7:1], exp[7:1]);
    check("R5 end bit", seen[0], 1'b1);
    check("R7 response word", rx_data, resp);
    check("R10 idle line", {busy, sd_clk, cmd_out, cmd_oe}, 64'b0010);
    if (poke) check("R9 ready low mid-frame", ready_leak, 1'b0);
  endtask

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // R6: command line never moves across an SD clock rise
  logic prev_sd, prev_cmd;
  always @(posedge clk) begin
    if (rst_n && !prev_sd && sd_clk === 1'b1) check("R6 steady at rise", cmd_out, prev_cmd);
    prev_sd  <= sd_clk;
    prev_cmd <= cmd_out;
  end

  initial begin
    prev_sd = 1'b0; prev_cmd = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 reset state", {sd_clk, cmd_out, cmd_oe, busy, rx_done, in_ready}, 64'b010001);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after reset", {sd_clk, cmd_out, busy}, 64'b010);
    run_frame(32'h0000_0000, 32'hFFFF_FFFF, 1'b0);
    run_frame(32'hFFFF_FFFF, 32'h0000_0000, 1'b0);
    run_frame(32'h4000_0000, 32'hA5A5_5A5A, 1'b1);
    run_frame(32'h1234_5678, 32'h8000_0001, 1'b1);
    for (int i = 0; i < 32; i++) run_frame(32'h1 << i, ~(32'h1 << i), i[0]);
    for (int i = 0; i < 8; i++) run_frame(~(32'h1 << (i*4)), 32'hC3C3_0F0F ^ i, 1'b1);
    // R9: nothing starts after a poked frame without a fresh word
    repeat (10) @(negedge clk);
    check("R9 no extra frame", {busy, sd_clk}, 64'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule